// File: doc/BRIEF.md
# PLL Power Sequencer

This controller takes a phase-locked loop from fully off to running, and back to off, without any help from software. On an enable request it releases the loop's bypass and then waits a settling time. It then releases the loop's reset and checks the lock indicator once every microsecond. When lock appears it turns the loop's output on. On a disable request it gates the output off first. After a short drain delay it asserts bypass and reset again in the same cycle.

The loop can also be owned by a shared hardware arbiter. When the vote-mode input is high, the sequencer leaves the three control bits alone. It raises a vote request and waits for the arbiter's active flag in place of lock. A disable in that mode only withdraws the vote.

All delays come from a microsecond tick. The tick is produced by dividing the system clock by a parameter, so a testbench can make the time scale short. The outputs `done`, `busy` and `timeout` report how each sequence ended.

Top module: `pll_seq`

## Requirements
- R1: During power-up, `bypass_rel` goes high before `reset_rel`, and `reset_rel` is high before `out_en` goes high.
- R2: From the cycle `bypass_rel` rises to the cycle `reset_rel` rises, at least SETTLE_US × CYC_PER_US clock cycles pass.
- R3: Once `reset_rel` is high, `lock_det` is sampled once per microsecond tick, up to POLL_MAX times. The first sample that finds it high sets `out_en` and gives a one-cycle `done` pulse.
- R4: If all POLL_MAX samples miss lock, `timeout` goes high and all four control outputs go low. This happens POLL_MAX × CYC_PER_US cycles after `reset_rel` rose. The block returns to idle, and `timeout` stays high until the next accepted request clears it.
- R5: With `vote_mode` high, an enable raises `vote_req` and waits for `active_flag`; `lock_det` has no effect. `bypass_rel`, `reset_rel` and `out_en` do not change. If `active_flag` never appears, the timeout of R4 applies.
- R6: In direct mode, if `bypass_rel`, `reset_rel` and `out_en` are all high when an enable arrives, the block gives a `done` pulse on the next cycle. No output changes and `busy` stays low.
- R7: During power-down, `out_en` falls first. At least CYC_PER_US × OFF_US cycles later, `reset_rel` and `bypass_rel` fall in the same cycle, together with a `done` pulse.
- R8: With `vote_mode` high, a disable clears only `vote_req` and gives a `done` pulse in the same cycle.
- R9: A request that arrives while `busy` is high is ignored, and `busy` stays high until the running sequence ends. If enable and disable arrive together in idle, enable wins.
- R10: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Power-up request, sampled when idle |
| dis_req | input | 1 | Power-down request, sampled when idle |
| vote_mode | input | 1 | High: use the shared-arbiter vote path |
| lock_det | input | 1 | Lock indicator from the loop |
| active_flag | input | 1 | Active indicator from the arbiter |
| bypass_rel | output | 1 | High releases the loop bypass |
| reset_rel | output | 1 | High releases the loop reset |
| out_en | output | 1 | High enables the loop output |
| vote_req | output | 1 | Vote to the shared arbiter |
| done | output | 1 | One-cycle pulse when a sequence completes |
| busy | output | 1 | High while a sequence is running |
| timeout | output | 1 | Sticky flag: lock or active never appeared |

## Verification
The bench runs the sequencer through these patterns:
- A direct power-up where lock arrives late. This separates correct ordering and settle timing from an early reset release.
- An enable on a loop that is already running. This separates the shortcut from a needless full restart.
- A direct power-down, to confirm the drain delay.
- A power-up where lock never arrives. This measures when the timeout fires and shows the flag is sticky until the next request.
- A vote-mode power-up with `lock_det` held high but `active_flag` late. This shows the block waits on the correct flag.
- A vote-mode disable.
- A vote-mode timeout.

Some requests are injected mid-sequence and must not change the sequence of output changes.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_SETTLE = 3'd1,
    S_POLL   = 3'd2,
    S_VPOLL  = 3'd3,
    S_DOFF   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/pll_seq_tick.sv
// Microsecond tick: one-cycle pulse every CYC_PER_US clocks after a restart.
module pll_seq_tick #(
  parameter int CYC_PER_US = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int W = (CYC_PER_US > 2) ? $clog2(CYC_PER_US) : 1;
  localparam logic [W-1:0] LAST = W'(CYC_PER_US - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/pll_seq_uscnt.sv
// Counts elapsed microsecond ticks since the last restart, saturating.
module pll_seq_uscnt #(
  parameter int MAX_US = 100,
  localparam int CW = $clog2(MAX_US + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] us_cnt
);
  localparam logic [CW-1:0] TOP = CW'(MAX_US);

  always_ff @(posedge clk) begin
    if (rst || clr)                  us_cnt <= '0;
    else if (tick && us_cnt != TOP)  us_cnt <= us_cnt + 1'b1;
  end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int SETTLE_US = 5,
  parameter int OFF_US    = 1,
  parameter int POLL_MAX  = 100,
  parameter int CW        = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_req,
  input  logic          dis_req,
  input  logic          vote_mode,
  input  logic          lock_det,
  input  logic          active_flag,
  input  logic          tick,
  input  logic [CW-1:0] us_cnt,
  output logic          tmr_clr,
  output logic          bypass_rel,
  output logic          reset_rel,
  output logic          out_en,
  output logic          vote_req,
  output logic          done,
  output logic          busy,
  output logic          timeout
);
  localparam logic [CW-1:0] SETTLE_C = CW'(SETTLE_US);
  localparam logic [CW-1:0] OFF_C    = CW'(OFF_US);
  localparam logic [CW-1:0] LAST_C   = CW'(POLL_MAX - 1);

  seq_state_t state;
  logic acc_en, acc_dis, settle_ok, off_ok, poll_last, all_on;

  always_comb begin
    acc_en    = (state == S_IDLE) && en_req;
    acc_dis   = (state == S_IDLE) && !en_req && dis_req;
    settle_ok = (state == S_SETTLE) && (us_cnt >= SETTLE_C);
    off_ok    = (state == S_DOFF) && (us_cnt >= OFF_C);
    poll_last = (us_cnt == LAST_C);
    all_on    = bypass_rel && reset_rel && out_en;
    tmr_clr   = acc_en || acc_dis || settle_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      bypass_rel <= 1'b0;
      reset_rel  <= 1'b0;
      out_en     <= 1'b0;
      vote_req   <= 1'b0;
      done       <= 1'b0;
      timeout    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (acc_en) begin
            timeout <= 1'b0;
            if (vote_mode) begin
              vote_req <= 1'b1;
              state    <= S_VPOLL;
            end else if (all_on) begin
              done <= 1'b1;
            end else begin
              bypass_rel <= 1'b1;
              state      <= S_SETTLE;
            end
          end else if (acc_dis) begin
            timeout <= 1'b0;
            if (vote_mode) begin
              vote_req <= 1'b0;
              done     <= 1'b1;
            end else begin
              out_en <= 1'b0;
              state  <= S_DOFF;
            end
          end
        end
        S_SETTLE: begin
          if (settle_ok) begin
            reset_rel <= 1'b1;
            state     <= S_POLL;
          end
        end
        S_POLL: begin
          if (tick) begin
            if (lock_det) begin
              out_en <= 1'b1;
              done   <= 1'b1;
              state  <= S_IDLE;
            end else if (poll_last) begin
              timeout    <= 1'b1;
              bypass_rel <= 1'b0;
              reset_rel  <= 1'b0;
              out_en     <= 1'b0;
              vote_req   <= 1'b0;
              state      <= S_IDLE;
            end
          end
        end
        S_VPOLL: begin
          if (tick) begin
            if (active_flag) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else if (poll_last) begin
              timeout    <= 1'b1;
              bypass_rel <= 1'b0;
              reset_rel  <= 1'b0;
              out_en     <= 1'b0;
              vote_req   <= 1'b0;
              state      <= S_IDLE;
            end
          end
        end
        S_DOFF: begin
          if (off_ok) begin
            bypass_rel <= 1'b0;
            reset_rel  <= 1'b0;
            done       <= 1'b1;
            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/pll_seq.sv
module pll_seq #(
  parameter int CYC_PER_US = 100,
  parameter int SETTLE_US  = 5,
  parameter int OFF_US     = 1,
  parameter int POLL_MAX   = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic en_req,
  input  logic dis_req,
  input  logic vote_mode,
  input  logic lock_det,
  input  logic active_flag,
  output logic bypass_rel,
  output logic reset_rel,
  output logic out_en,
  output logic vote_req,
  output logic done,
  output logic busy,
  output logic timeout
);
  localparam int MAX_A  = (SETTLE_US > OFF_US) ? SETTLE_US : OFF_US;
  localparam int MAX_US = (MAX_A > POLL_MAX) ? MAX_A : POLL_MAX;
  localparam int CW     = $clog2(MAX_US + 1);

  logic          tick;
  logic          tmr_clr;
  logic [CW-1:0] us_cnt;

  pll_seq_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(tick)
  );

  pll_seq_uscnt #(.MAX_US(MAX_US)) u_uscnt (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(tick), .us_cnt(us_cnt)
  );

  pll_seq_fsm #(
    .SETTLE_US(SETTLE_US), .OFF_US(OFF_US), .POLL_MAX(POLL_MAX), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
    .vote_mode(vote_mode), .lock_det(lock_det), .active_flag(active_flag),
    .tick(tick), .us_cnt(us_cnt), .tmr_clr(tmr_clr),
    .bypass_rel(bypass_rel), .reset_rel(reset_rel), .out_en(out_en),
    .vote_req(vote_req), .done(done), .busy(busy), .timeout(timeout)
  );
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
  parameter int CYC_PER_US = 100,
  parameter int SETTLE_US  = 5
) (
  input logic clk,
  input logic rst,
  input logic vote_mode,
  input logic bypass_rel,
  input logic reset_rel,
  input logic out_en,
  input logic vote_req,
  input logic done,
  input logic busy,
  input logic timeout
);
  localparam int unsigned GAP_MIN = SETTLE_US * CYC_PER_US;

  int unsigned gap_cnt;

  always_ff @(posedge clk) begin
    if (rst || !bypass_rel)           gap_cnt <= 0;
    else if (gap_cnt != 32'hFFFF_FFFF) gap_cnt <= gap_cnt + 1;
  end

  // R1
  order_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_rel) |-> bypass_rel);
  // R1
  order_out_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_en) |-> (bypass_rel && reset_rel));
  // R2
  settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_rel) |-> (gap_cnt >= GAP_MIN));
  // R3
  out_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_en) |-> ($past(busy) && !busy && done));
  // R4
  timeout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    timeout |-> (!bypass_rel && !reset_rel && !out_en && !vote_req && !busy));
  // R5
  vote_hands_off_chk: assert property (@(posedge clk) disable iff (rst)
    (vote_mode && $past(vote_mode)) |-> ($stable(bypass_rel) && $stable(reset_rel) && $stable(out_en)));
  // R7
  down_order_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(reset_rel) |-> (!out_en && !bypass_rel));
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind pll_seq pll_seq_chk #(.CYC_PER_US(CYC_PER_US), .SETTLE_US(SETTLE_US)) u_chk (
  .clk(clk), .rst(rst), .vote_mode(vote_mode), .bypass_rel(bypass_rel),
  .reset_rel(reset_rel), .out_en(out_en), .vote_req(vote_req), .done(done),
  .busy(busy), .timeout(timeout)
);

// File: tb/sim_pll_seq.sv
module sim_pll_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CYC  = 4;
  localparam int SETL = 5;
  localparam int OFFU = 1;
  localparam int POLL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_req = 1'b0, dis_req = 1'b0, vote_mode = 1'b0;
  logic lock_det = 1'b0, active_flag = 1'b0;
  logic bypass_rel, reset_rel, out_en, vote_req, done, busy, timeout;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit run_mon = 1'b0;
  logic [5:0] exp_q[$];
  string tag_q[$];
  logic [5:0] cur, prev;
  int t_a, t_b;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pll_seq #(.CYC_PER_US(CYC), .SETTLE_US(SETL), .OFF_US(OFFU), .POLL_MAX(POLL)) u0 (
    .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
    .vote_mode(vote_mode), .lock_det(lock_det), .active_flag(active_flag),
    .bypass_rel(bypass_rel), .reset_rel(reset_rel), .out_en(out_en),
    .vote_req(vote_req), .done(done), .busy(busy), .timeout(timeout)
  );

  // vector bits: [5] bypass_rel [4] reset_rel [3] out_en [2] vote_req [1] done [0] timeout
  function automatic logic [5:0] outs();
    return {bypass_rel, reset_rel, out_en, vote_req, done, timeout};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [5:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor: every change of the output vector must match the next expected item
  always @(negedge clk) begin
    if (run_mon) begin
      cur = outs();
      if (cur !== prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected output change", int'(cur), int'(prev));
        end else begin
          logic [5:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cur === e, t, int'(cur), int'(e));
        end
        prev = cur;
      end
    end
  end

  task automatic pulse_en();
    en_req = 1'b1; @(negedge clk); en_req = 1'b0;
  endtask

  task automatic pulse_dis();
    dis_req = 1'b1; @(negedge clk); dis_req = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(outs() == 6'b0, "R10 outputs after reset", int'(outs()), 0);
    chk(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
    prev = outs();
    run_mon = 1'b1;

    // direct power-up, lock arrives late; mid-sequence requests injected
    push(6'b100000, "R1 bypass released first");
    push(6'b110000, "R1 reset released second");
    push(6'b111010, "R3 output on with done");
    push(6'b111000, "R3 done is one pulse");
    pulse_en();
    t_a = cyc;
    repeat (2) @(negedge clk);
    dis_req = 1'b1; en_req = 1'b1;
    @(negedge clk);
    dis_req = 1'b0; en_req = 1'b0;
    chk(busy == 1'b1, "R9 busy held during settle", int'(busy), 1);
    while (!reset_rel) @(negedge clk);
    t_b = cyc;
    chk((t_b - t_a) >= SETL*CYC, "R2 settle gap cycles", t_b - t_a, SETL*CYC);
    repeat (3) @(negedge clk);
    lock_det = 1'b1;
    wait_idle();
    chk(out_en == 1'b1, "R3 output stays on", int'(out_en), 1);

    // enable while already on: shortcut
    push(6'b111010, "R6 immediate done");
    push(6'b111000, "R6 done ends, outputs kept");
    pulse_en();
    chk(busy == 1'b0, "R6 busy stays low", int'(busy), 0);
    wait_idle();

    // direct power-down
    push(6'b110000, "R7 output off first");
    push(6'b000010, "R7 reset and bypass off together");
    push(6'b000000, "R7 done ends");
    pulse_dis();
    lock_det = 1'b0;
    t_a = cyc;
    while (bypass_rel) @(negedge clk);
    t_b = cyc;
    chk((t_b - t_a) >= OFFU*CYC, "R7 drain gap cycles", t_b - t_a, OFFU*CYC);
    wait_idle();

    // power-up with no lock: timeout
    push(6'b100000, "R1 bypass released (timeout run)");
    push(6'b110000, "R1 reset released (timeout run)");
    push(6'b000001, "R4 timeout clears outputs");
    pulse_en();
    while (!reset_rel) @(negedge clk);
    t_a = cyc;
    while (!timeout) @(negedge clk);
    t_b = cyc;
    chk((t_b - t_a) >= POLL*CYC && (t_b - t_a) <= POLL*CYC + 2,
        "R4 timeout after all polls", t_b - t_a, POLL*CYC);
    repeat (20) @(negedge clk);
    chk(timeout == 1'b1, "R4 timeout sticky", int'(timeout), 1);
    chk(busy == 1'b0, "R4 idle after timeout", int'(busy), 0);

    // next request clears the flag
    push(6'b000000, "R4 timeout cleared by request");
    push(6'b000010, "R7 done after power-down");
    push(6'b000000, "R7 done ends");
    pulse_dis();
    wait_idle();

    // vote mode: lock high but active late; must wait on active
    vote_mode = 1'b1;
    lock_det  = 1'b1;
    push(6'b000100, "R5 vote raised, bits untouched");
    push(6'b000110, "R5 done on active flag");
    push(6'b000100, "R5 done ends");
    pulse_en();
    repeat (POLL*CYC/2) @(negedge clk);
    chk(busy == 1'b1, "R5 lock ignored in vote mode", int'(busy), 1);
    active_flag = 1'b1;
    wait_idle();

    // vote disable
    push(6'b000010, "R8 vote withdrawn with done");
    push(6'b000000, "R8 done ends");
    pulse_dis();
    active_flag = 1'b0;
    wait_idle();

    // vote timeout
    push(6'b000100, "R5 vote raised again");
    push(6'b000001, "R5 timeout without active");
    pulse_en();
    wait_idle();

    chk(exp_q.size() == 0, "R9 all expected changes seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule